// File: doc/BRIEF.md
# Multiplexed Bus Transfer-Acknowledge Generator

This block sits on the target side of a multiplexed external memory bus. It watches the host's address-latch-enable and active-low chip-select strobes, and it drives the active-low transfer-acknowledge that ends each transfer. Both strobes and a contention flag from a dual-port memory arbiter are asynchronous to the local clock. They pass through two-flop synchronizers before any edge is detected. A transfer starts on a falling edge of either synchronized strobe.

After a start, the block keeps acknowledge high for at least a programmed number of wait cycles. It keeps waiting for as long as the arbiter reports that the other memory port is busy. It then drives acknowledge low for exactly one clock. When the host splits a wide access to an 8-bit port into byte transfers, each byte begins with its own address-latch-enable pulse. Each byte therefore gets its own acknowledge. The acknowledge driver is enabled only while the synchronized chip-select is active. A status output holds the number of wait cycles that the last acknowledged transfer took.

The block has no data path, so it has no valid/ready stream interface and no back-pressure rules. All pins are plain control and status pins. A pulse that lands on the host's sampling edge may cost the host one extra wait state, and the host tolerates this.

Top module: `mux_ack_gen`

## Requirements
- R1: After reset, `ack_n_o` is 1, `ack_oe_o` is 0 and `last_waits_o` is 0.
- R2: A 1-to-0 transition of `ale_i` starts a transfer. It is seen three clock edges after the input changes: two synchronizer flops and one edge register.
- R3: A 1-to-0 transition of `cs_n_i` also starts a transfer, with the same latency as R2.
- R4: When the arbiter is not busy, `ack_n_o` goes low exactly `wait_min_i` + 1 clock edges after the edge at which the start is detected.
- R5: While the synchronized `peer_busy_i` is 1, the acknowledge is withheld and the wait count keeps advancing. The acknowledge fires on the first edge at which the count is at least `wait_min_i` and busy is 0.
- R6: `ack_n_o` is low for exactly one clock cycle per transfer.
- R7: A start detected while a transfer is still waiting restarts the count from zero. The pending acknowledge is dropped, so only one pulse follows the latest start.
- R8: Two address-latch-enable pulses under one continuous chip-select produce two separate acknowledge pulses.
- R9: With `wait_min_i` = 0 and no contention, acknowledge is low in the first cycle after the start is detected.
- R10: `ack_oe_o` is 1 exactly when the two-flop-synchronized `cs_n_i` is 0.
- R11: `last_waits_o` changes only together with an acknowledge pulse. It then holds the number of wait cycles counted since the start: zero when the acknowledge fires on the first eligible edge.
- R12: The wait counter saturates at 2^`CNT_W`-1 and does not wrap. `last_waits_o` then reports the saturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Host address-latch-enable, asynchronous |
| cs_n_i | input | 1 | Host chip-select, active low, asynchronous |
| peer_busy_i | input | 1 | Arbiter flag: other dual-port side is busy, asynchronous |
| wait_min_i | input | 4 | Minimum wait cycles before acknowledge (static configuration) |
| ack_n_o | output | 1 | Transfer-acknowledge value, active low |
| ack_oe_o | output | 1 | Output enable of the acknowledge driver (0 = high impedance) |
| last_waits_o | output | CNT_W | Wait cycles taken by the last acknowledged transfer |

## Verification
The bench builds the block with `CNT_W` = 4. At that width the counter saturates after fifteen cycles, so a long contention stall exercises saturation within a short run. Programmed minimums of 0, 3 and 8 cover the immediate acknowledge, an ordinary wait and a wait long enough to be cut short by a second start. Split byte transfers, restarts and busy pulses placed before, during and after the minimum window are compared cycle by cycle against a behavioural model.

// File: rtl/mb_ack_pkg.sv
package mb_ack_pkg;
  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_WAIT = 1'b1
  } xfer_state_t;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned WMIN_W      = 4;
endpackage

// File: rtl/mb_sync.sv
module mb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mb_start_det.sv
module mb_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ale_s,
  input  logic cs_n_s,
  output logic start_o
);
  logic ale_q, cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      ale_q  <= ale_s;
      cs_n_q <= cs_n_s;
    end
  end

  assign start_o = (ale_q & ~ale_s) | (cs_n_q & ~cs_n_s);

  // R2/R3: a detected start implies that one of the strobes fell
  p_start_has_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (ale_q != ale_s) || (cs_n_q != cs_n_s));
endmodule

// File: rtl/mb_ack_ctr.sv
module mb_ack_ctr
  import mb_ack_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              busy_s,
  input  logic [WMIN_W-1:0] wait_min_i,
  output logic              ack_n_o,
  output logic [CNT_W-1:0]  last_waits_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  xfer_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wmin_ext;
  logic             fire;

  assign wmin_ext = CNT_W'(wait_min_i);
  assign fire     = (state == XF_WAIT) && !start_i && (cnt >= wmin_ext) && !busy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= XF_IDLE;
      cnt          <= '0;
      ack_n_o      <= 1'b1;
      last_waits_o <= '0;
    end else begin
      ack_n_o <= 1'b1;
      if (start_i) begin
        state <= XF_WAIT;
        cnt   <= '0;
      end else if (fire) begin
        state        <= XF_IDLE;
        ack_n_o      <= 1'b0;
        last_waits_o <= cnt;
      end else if (state == XF_WAIT && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_ack_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |=> ack_n_o);
  p_restart_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ack_n_o);
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_s |=> ack_n_o);
  p_min_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |-> last_waits_o >= CNT_W'($past(wait_min_i)));
  p_last_with_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_waits_o) |-> !ack_n_o);
endmodule

// File: rtl/mux_ack_gen.sv
module mux_ack_gen
  import mb_ack_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic              cs_n_i,
  input  logic              peer_busy_i,
  input  logic [WMIN_W-1:0] wait_min_i,
  output logic              ack_n_o,
  output logic              ack_oe_o,
  output logic [CNT_W-1:0]  last_waits_o
);
  logic [2:0] raw, synced;
  logic       start;

  // bit 2: ale, bit 1: cs_n, bit 0: busy
  assign raw = {ale_i, cs_n_i, peer_busy_i};

  mb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  mb_start_det u_det (
    .clk(clk), .rst_n(rst_n), .ale_s(synced[2]), .cs_n_s(synced[1]), .start_o(start)
  );

  mb_ack_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_s(synced[0]),
    .wait_min_i(wait_min_i), .ack_n_o(ack_n_o), .last_waits_o(last_waits_o)
  );

  assign ack_oe_o = ~synced[1];

  // R10: the driver enable follows chip-select after the synchronizer delay
  p_oe_tracks_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_i) |=> ##1 ack_oe_o);
endmodule

// File: tb/mux_ack_gen_tb.sv
module mux_ack_gen_tb;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ale = 1'b0, cs_n = 1'b1, busy = 1'b0;
  logic [3:0]    wmin = 4'd3;
  logic          ack_n, ack_oe;
  logic [CW-1:0] last;

  int vectors = 0, fails = 0, cycles = 0, acks = 0;
  string tag = "R1";

  // reference model state
  int a1 = 0, a2 = 0, a3 = 0, c1 = 1, c2 = 1, c3 = 1, b1 = 0, b2 = 0;
  int m_st = 0, m_cnt = 0, m_ack = 1, m_last = 0;

  always #5 clk = ~clk;

  mux_ack_gen #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_n_i(cs_n), .peer_busy_i(busy),
    .wait_min_i(wmin), .ack_n_o(ack_n), .ack_oe_o(ack_oe), .last_waits_o(last)
  );

  always @(posedge clk) begin
    int start, na1, nc1, nb1;
    if (rst_n) begin
      start = ((a3 == 1 && a2 == 0) || (c3 == 1 && c2 == 0)) ? 1 : 0;
      m_ack = 1;
      if (start == 1) begin
        m_st = 1; m_cnt = 0;
      end else if (m_st == 1) begin
        if (m_cnt >= int'(wmin) && b2 == 0) begin
          m_ack = 0; m_st = 0; m_last = m_cnt;
        end else if (m_cnt < CMAX) m_cnt++;
      end
      na1 = int'(ale); nc1 = int'(cs_n); nb1 = int'(busy);
      a3 = a2; a2 = a1; a1 = na1;
      c3 = c2; c2 = c1; c1 = nc1;
      b2 = b1; b1 = nb1;
    end
  end

  task automatic cmp(input string t, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", t, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      cmp(tag, int'(ack_n), m_ack, "ack_n");
      cmp("R10", int'(ack_oe), (c2 == 0) ? 1 : 0, "ack_oe");
      cmp("R11", int'(last), m_last, "last_waits");
      if (ack_n == 1'b0) acks++;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ale_pulse();
    ale = 1'b1; idle(2); ale = 1'b0;
  endtask

  initial begin
    int k;
    idle(3);
    // R1: reset values
    cmp("R1", int'(ack_n), 1, "ack_n reset");
    cmp("R1", int'(ack_oe), 0, "ack_oe reset");
    cmp("R1", int'(last), 0, "last reset");
    rst_n = 1'b1;
    idle(3);

    // R3 then R2: chip-select falls, then an ALE pulse, minimum wait 3
    tag = "R3"; wmin = 4'd3; cs_n = 1'b0; idle(4);
    tag = "R2"; ale_pulse(); idle(10);
    tag = "R4"; cs_n = 1'b1; idle(6);

    // R4 with no ALE: chip-select alone starts the transfer
    tag = "R4"; cs_n = 1'b0; idle(10); cs_n = 1'b1; idle(4);

    // R9: zero minimum
    tag = "R9"; wmin = 4'd0; cs_n = 1'b0; idle(6);
    k = acks; ale_pulse(); idle(6);
    cmp("R9", acks - k, 1, "acks with zero wait");
    cs_n = 1'b1; idle(4);

    // R5: contention stalls the acknowledge
    tag = "R5"; wmin = 4'd3; cs_n = 1'b0; idle(6);
    ale_pulse(); busy = 1'b1; idle(7); busy = 1'b0; idle(8);
    ale_pulse(); idle(4); busy = 1'b1; idle(1); busy = 1'b0; idle(8);
    cs_n = 1'b1; idle(4);

    // R8: split byte transfers under one chip-select
    tag = "R8"; wmin = 4'd2; cs_n = 1'b0; idle(8);
    k = acks;
    ale_pulse(); idle(8); ale_pulse(); idle(8);
    cmp("R8", acks - k, 2, "acks for two byte transfers");
    cs_n = 1'b1; idle(4);

    // R7: restart before acknowledge drops the pending one
    tag = "R7"; wmin = 4'd8; cs_n = 1'b0; idle(16);
    k = acks;
    ale_pulse(); idle(4); ale_pulse(); idle(16);
    cmp("R7", acks - k, 1, "acks after restart");
    cmp("R6", int'(ack_n), 1, "ack released");
    cs_n = 1'b1; idle(4);

    // R12: long stall saturates the counter
    tag = "R12"; wmin = 4'd2; cs_n = 1'b0; idle(6);
    busy = 1'b1; ale_pulse(); idle(30); busy = 1'b0; idle(6);
    cmp("R12", int'(last), CMAX, "saturated wait count");
    cs_n = 1'b1; idle(6);

    // R6: exactly one acknowledge per simple transfer
    tag = "R6"; wmin = 4'd1; cs_n = 1'b0; idle(6);
    k = acks; ale_pulse(); idle(8);
    cmp("R6", acks - k, 1, "single pulse");
    cs_n = 1'b1; idle(6);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule